// File: doc/BRIEF.md
# Test-Clock Activity Monitor

This block watches a second clock (the test clock) from a free-running reference clock and says whether the test clock is alive. The test domain flips a single bit on every one of its rising edges. The reference domain brings that bit across a synchronizer, detects each change, and decides that the test clock is running once it has seen enough changes close together. If the changes stop for too long, it declares the clock lost. The block handles test clocks from the reference frequency down to a fixed fraction of it. With a 125 MHz reference, that covers 125, 25 and 2.5 MHz test clocks.

The verdict is reported in both domains. The reference domain gets a running flag. The test domain gets the same flag back through a synchronizer, together with its inverse. The inverse is a halted flag meant to hold the receive logic clocked by the test clock in reset until the reference domain has confirmed that the clock is healthy. Pulling the reference reset low clears every running indication.

Top module: `clkdet_monitor`

## Requirements
- R1: While `ref_rst_n` is low, `ref_running` reads 0 one reference cycle later. After two test-clock rising edges under reset, `tst_running` reads 0 and `tst_halted` reads 1.
- R2: `ref_running` rises only after LOCK_TOGGLES (4) test-clock rising edges, counted after reset release or after a loss. Each counted edge must come before the timeout expires. A single edge, or three edges, never sets it.
- R3: If no test-clock edge is detected for TIMEOUT_MULT×RATIO_MAX (4×50 = 200) reference cycles, `ref_running` falls. Gaps shorter than that keep it high.
- R4: Once locked, `ref_running` stays high for any steady test clock whose period is 1 to 50 reference periods.
- R5: `tst_running` equals the value of `ref_running` sampled at the test-clock rising edge before the most recent one (a two-stage synchronizer).
- R6: `tst_halted` is always the inverse of `tst_running`.
- R7: After a loss, the edge count restarts from zero. Locking again needs four fresh edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock |
| ref_rst_n | input | 1 | Synchronous active-low reset, reference domain; also forwarded to the test domain |
| tst_clk | input | 1 | Clock under observation |
| ref_running | output | 1 | Test clock judged alive, reference domain |
| tst_running | output | 1 | `ref_running` synchronized into the test domain |
| tst_halted | output | 1 | Inverse of `tst_running`; reset for test-domain logic |

## Verification
The bench uses the default parameters: a 50:1 maximum ratio, a 200-cycle timeout, a 4-edge lock count and two synchronizer stages. These defaults let it drive test clocks at 1, 2, 5, 25 and 50 reference periods without a false loss. They also make a stall of a few hundred cycles enough to force a genuine timeout. With them, bursts of one and three edges sit just below the lock threshold, so the glitch rejection and the count restart after a loss are both exercised at the exact boundary.

// File: rtl/clkdet_pkg.sv
// Shared helpers for the test-clock activity monitor.
// Assumes: counts passed to bits_for are at least 1.
package clkdet_pkg;

    // Width of a counter that holds the values 0 .. n-1
    function automatic int unsigned bits_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Lock verdict held in the reference domain
    typedef enum logic {
        LK_DOWN = 1'b0,
        LK_UP   = 1'b1
    } lock_state_e;

endpackage

// File: rtl/clkdet_tst_side.sv
// Test-clock side of the activity monitor.
// Flips a bit on every test-clock rising edge and brings the reference
// verdict and the reference reset into the test domain.
// Assumes: SYNC_STAGES >= 2; the reference reset is held for several
// test-clock periods so that the toggle bit is parked at 0 on release.
module clkdet_tst_side #(
    parameter int SYNC_STAGES = 2
) (
    input  logic tst_clk,
    input  logic ref_rst_n,
    input  logic ref_running,
    output logic tst_toggle,
    output logic tst_running
);

    logic [SYNC_STAGES-1:0] rst_chain;
    logic [SYNC_STAGES-1:0] run_chain;
    logic                   toggle_q;
    logic                   rst_ok;

    // Bring the reference reset into the test domain
    always_ff @(posedge tst_clk) begin
        rst_chain <= {rst_chain[SYNC_STAGES-2:0], ref_rst_n};
    end

    assign rst_ok = rst_chain[SYNC_STAGES-1];

    // Flip the activity bit on every test-clock edge outside reset
    always_ff @(posedge tst_clk) begin
        if (!rst_ok) begin
            toggle_q <= 1'b0;
        end else begin
            toggle_q <= ~toggle_q;
        end
    end

    // Synchronize the reference verdict into the test domain
    always_ff @(posedge tst_clk) begin
        if (!rst_ok) begin
            run_chain <= '0;
        end else begin
            run_chain <= {run_chain[SYNC_STAGES-2:0], ref_running};
        end
    end

    assign tst_toggle  = toggle_q;
    assign tst_running = run_chain[SYNC_STAGES-1];

endmodule

// File: rtl/clkdet_edge_sync.sv
// Reference-side synchronizer and change detector for the activity bit.
// Emits a one-cycle pulse each time the synchronized bit changes.
// Assumes: SYNC_STAGES >= 2.
module clkdet_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic ref_rst_n,
    input  logic tst_toggle,
    output logic edge_pulse
);

    localparam int CHAIN_LEN = SYNC_STAGES + 1;

    logic [CHAIN_LEN-1:0] chain;

    // One flop per stage; the last stage only remembers the previous value
    for (genvar g = 0; g < CHAIN_LEN; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge ref_clk) begin
                if (!ref_rst_n) chain[0] <= 1'b0;
                else            chain[0] <= tst_toggle;
            end
        end else begin : g_next
            always_ff @(posedge ref_clk) begin
                if (!ref_rst_n) chain[g] <= 1'b0;
                else            chain[g] <= chain[g-1];
            end
        end
    end

    assign edge_pulse = chain[CHAIN_LEN-1] ^ chain[CHAIN_LEN-2];

endmodule

// File: rtl/clkdet_lock_fsm.sv
// Lock decision for the activity monitor, reference domain.
// Counts detected edges up to LOCK_TOGGLES and declares the test clock
// running; a gap of TIMEOUT_CYCLES cycles without an edge drops the verdict
// and clears the edge count.
// Assumes: LOCK_TOGGLES >= 1, TIMEOUT_CYCLES >= 2.
module clkdet_lock_fsm
    import clkdet_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 200,
    parameter int LOCK_TOGGLES   = 4,
    parameter int IDLE_W         = bits_for(TIMEOUT_CYCLES),
    parameter int LOCK_W         = bits_for(LOCK_TOGGLES + 1)
) (
    input  logic              ref_clk,
    input  logic              ref_rst_n,
    input  logic              edge_pulse,
    output logic              running,
    output logic [IDLE_W-1:0] idle_cnt,
    output logic [LOCK_W-1:0] lock_cnt
);

    localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(TIMEOUT_CYCLES - 1);
    localparam logic [LOCK_W-1:0] LOCK_FULL = LOCK_W'(LOCK_TOGGLES);
    localparam logic [LOCK_W-1:0] LOCK_PRE  = LOCK_W'(LOCK_TOGGLES - 1);

    lock_state_e state_q;

    // Track the edge gap, count edges and hold the lock verdict
    always_ff @(posedge ref_clk) begin
        if (!ref_rst_n) begin
            idle_cnt <= '0;
            lock_cnt <= '0;
            state_q  <= LK_DOWN;
        end else if (edge_pulse) begin
            idle_cnt <= '0;
            if (lock_cnt != LOCK_FULL) lock_cnt <= lock_cnt + 1'b1;
            if (lock_cnt == LOCK_PRE)  state_q  <= LK_UP;
        end else if (idle_cnt == IDLE_LAST) begin
            lock_cnt <= '0;
            state_q  <= LK_DOWN;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign running = (state_q == LK_UP);

endmodule

// File: rtl/clkdet_monitor.sv
// Top of the test-clock activity monitor.
// Ties the test-side toggle and synchronizers to the reference-side
// change detector and lock decision.
// Assumes: ref_clk runs freely; tst_clk is at most RATIO_MAX times slower.
module clkdet_monitor
    import clkdet_pkg::*;
#(
    parameter int RATIO_MAX    = 50,
    parameter int TIMEOUT_MULT = 4,
    parameter int LOCK_TOGGLES = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic ref_clk,
    input  logic ref_rst_n,
    input  logic tst_clk,
    output logic ref_running,
    output logic tst_running,
    output logic tst_halted
);

    localparam int TIMEOUT_CYCLES = RATIO_MAX * TIMEOUT_MULT;
    localparam int IDLE_W         = bits_for(TIMEOUT_CYCLES);
    localparam int LOCK_W         = bits_for(LOCK_TOGGLES + 1);

    logic              tst_toggle;
    logic              edge_pulse;
    logic [IDLE_W-1:0] idle_cnt;
    logic [LOCK_W-1:0] lock_cnt;

    clkdet_tst_side #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tst (
        .tst_clk     (tst_clk),
        .ref_rst_n   (ref_rst_n),
        .ref_running (ref_running),
        .tst_toggle  (tst_toggle),
        .tst_running (tst_running)
    );

    clkdet_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .ref_clk    (ref_clk),
        .ref_rst_n  (ref_rst_n),
        .tst_toggle (tst_toggle),
        .edge_pulse (edge_pulse)
    );

    clkdet_lock_fsm #(
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
        .LOCK_TOGGLES   (LOCK_TOGGLES),
        .IDLE_W         (IDLE_W),
        .LOCK_W         (LOCK_W)
    ) u_lock (
        .ref_clk    (ref_clk),
        .ref_rst_n  (ref_rst_n),
        .edge_pulse (edge_pulse),
        .running    (ref_running),
        .idle_cnt   (idle_cnt),
        .lock_cnt   (lock_cnt)
    );

    // Halted is the test domain's reset for downstream logic
    assign tst_halted = ~tst_running;

endmodule

// File: rtl/clkdet_monitor_chk.sv
// Property checker for the activity monitor, bound into the top module.
// Observes the reference-side verdict, edge pulses and counters.
module clkdet_monitor_chk #(
    parameter int TIMEOUT_CYCLES = 200,
    parameter int LOCK_TOGGLES   = 4,
    parameter int IDLE_W         = 8,
    parameter int LOCK_W         = 3
) (
    input logic              ref_clk,
    input logic              ref_rst_n,
    input logic              ref_running,
    input logic              edge_pulse,
    input logic [IDLE_W-1:0] idle_cnt,
    input logic [LOCK_W-1:0] lock_cnt
);

    // R1: reset clears the reference verdict on the next cycle
    p_reset_clears_r1: assert property (@(posedge ref_clk)
        !ref_rst_n |=> !ref_running);

    // R2: the verdict rises only on the edge that completes the lock count
    p_lock_on_count_r2: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        $rose(ref_running) |-> ($past(edge_pulse) && ($past(lock_cnt) == LOCK_W'(LOCK_TOGGLES - 1))));

    // R3: the verdict falls only after a full timeout gap
    p_fall_on_timeout_r3: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        $fell(ref_running) |-> ($past(idle_cnt) == IDLE_W'(TIMEOUT_CYCLES - 1)));

    // R4: a detected edge while running keeps the verdict
    p_edge_keeps_run_r4: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (ref_running && edge_pulse) |=> ref_running);

    // R7: after a loss the edge count restarts from zero
    p_count_restart_r7: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        $fell(ref_running) |-> (lock_cnt == '0));

endmodule

bind clkdet_monitor clkdet_monitor_chk #(
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES),
    .LOCK_TOGGLES   (LOCK_TOGGLES),
    .IDLE_W         (IDLE_W),
    .LOCK_W         (LOCK_W)
) u_chk (
    .ref_clk     (ref_clk),
    .ref_rst_n   (ref_rst_n),
    .ref_running (ref_running),
    .edge_pulse  (edge_pulse),
    .idle_cnt    (idle_cnt),
    .lock_cnt    (lock_cnt)
);

// File: tb/clkdet_monitor_tb_top.sv
// Bench for the activity monitor: a behavioural model of edges, gaps and
// lock state, compared on every reference and test clock.
module clkdet_monitor_tb_top;

    localparam int LOCK    = 4;
    localparam int TIMEOUT = 200;

    logic ref_clk   = 1'b0;
    logic ref_rst_n = 1'b0;
    logic tst_clk   = 1'b0;
    logic ref_running;
    logic tst_running;
    logic tst_halted;

    int    n_chk  = 0;
    int    n_fail = 0;
    string phase  = "R1";

    clkdet_monitor dut_i (
        .ref_clk     (ref_clk),
        .ref_rst_n   (ref_rst_n),
        .tst_clk     (tst_clk),
        .ref_running (ref_running),
        .tst_running (tst_running),
        .tst_halted  (tst_halted)
    );

    always #10 ref_clk = ~ref_clk;

    // Test clock: period tst_k reference cycles, rising 5 ns after a ref edge
    int tst_k  = 1;
    bit tst_en = 1'b0;
    int ph     = 0;
    initial forever begin
        @(posedge ref_clk);
        if (!tst_en) begin
            ph = 0;
            #5 tst_clk = 1'b0;
        end else begin
            if (ph == 0) begin
                #5 tst_clk = 1'b1;
                if (tst_k == 1) begin
                    #10 tst_clk = 1'b0;
                end
            end else if (ph == tst_k / 2) begin
                #5 tst_clk = 1'b0;
            end
            ph = (ph + 1 >= tst_k) ? 0 : ph + 1;
        end
    end

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural model state
    int   rise_idx   = 0;
    int   consec     = 0;
    int   cyc_since  = 100000;
    int   age        = 0;
    bit   pending    = 1'b0;
    int   rst_recent = 4;
    logic hist[$];

    // Test-domain model: count usable edges and record the sampled verdict
    always @(posedge tst_clk) begin
        if (!ref_rst_n) begin
            rise_idx   = 0;
            rst_recent = 4;
        end else begin
            rise_idx++;
            if (rise_idx >= 3) pending = 1'b1;
            if (rst_recent > 0) rst_recent--;
        end
        hist.push_back(ref_running);
        if (hist.size() > 4) void'(hist.pop_front());
    end

    // R5 and R6 compared on every test-clock falling edge
    always @(negedge tst_clk) begin
        if (ref_rst_n && rst_recent == 0 && hist.size() >= 2) begin
            chk("R5", "tst_running follows ref_running", tst_running, hist[hist.size()-2]);
            chk("R6", "tst_halted inverse", tst_halted, ~tst_running);
        end
    end

    // Reference-domain model compared on every falling reference edge
    always @(negedge ref_clk) begin
        if (!ref_rst_n) begin
            consec    = 0;
            cyc_since = 100000;
            age       = 0;
            pending   = 1'b0;
            chk("R1", "ref_running under reset", ref_running, 1'b0);
        end else begin
            if (cyc_since < 100000) cyc_since++;
            if (pending) begin
                pending   = 1'b0;
                cyc_since = 0;
                consec++;
                if (consec == LOCK) age = 0;
            end else if (cyc_since == TIMEOUT + 5) begin
                consec = 0;
            end
            if (consec >= LOCK) age++;
            if (consec < LOCK)
                chk(phase, "ref_running before lock count", ref_running, 1'b0);
            else if (age >= 5 && cyc_since < TIMEOUT - 1)
                chk(phase, "ref_running while locked", ref_running, 1'b1);
        end
    end

    task automatic wait_ref(input int n);
        repeat (n) @(negedge ref_clk);
        #1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog
    initial begin
        repeat (60000) @(posedge ref_clk);
        n_fail++;
        $display("FAIL R4 watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state with the test clock running
        phase  = "R1";
        tst_k  = 1;
        tst_en = 1'b1;
        wait_ref(20);
        chk("R1", "reset ref_running", ref_running, 1'b0);
        chk("R1", "reset tst_running", tst_running, 1'b0);
        chk("R1", "reset tst_halted", tst_halted, 1'b1);

        // R2: just after release, too few edges to lock
        phase     = "R2";
        ref_rst_n = 1'b1;
        wait_ref(3);
        chk("R2", "no lock after release", ref_running, 1'b0);

        // R4: steady clocks at several ratios
        phase = "R4";
        wait_ref(200);
        chk("R4", "locked at ratio 1", ref_running, 1'b1);
        chk("R5", "test side sees lock", tst_running, 1'b1);
        chk("R6", "halted released", tst_halted, 1'b0);
        tst_k = 5;
        wait_ref(500);
        chk("R4", "locked at ratio 5", ref_running, 1'b1);
        tst_k = 50;
        wait_ref(2000);
        chk("R4", "locked at ratio 50", ref_running, 1'b1);
        tst_k = 25;
        wait_ref(1000);
        chk("R4", "locked at ratio 25", ref_running, 1'b1);

        // R3: stall the test clock
        phase  = "R3";
        tst_en = 1'b0;
        wait_ref(150);
        chk("R3", "still running inside timeout", ref_running, 1'b1);
        wait_ref(100);
        chk("R3", "lost after timeout", ref_running, 1'b0);

        // R2/R7: one edge, then three edges, never lock
        phase  = "R7";
        tst_k  = 4;
        tst_en = 1'b1;
        wait_ref(4);
        tst_en = 1'b0;
        wait_ref(300);
        chk("R2", "single edge rejected", ref_running, 1'b0);
        tst_en = 1'b1;
        wait_ref(12);
        tst_en = 1'b0;
        wait_ref(300);
        chk("R7", "three edges after loss rejected", ref_running, 1'b0);

        // R7: fresh clock relocks
        tst_k  = 2;
        tst_en = 1'b1;
        wait_ref(100);
        chk("R7", "relock after loss", ref_running, 1'b1);

        // R1: reset while running
        phase     = "R1";
        ref_rst_n = 1'b0;
        wait_ref(30);
        chk("R1", "reset drops ref_running", ref_running, 1'b0);
        chk("R1", "reset drops tst_running", tst_running, 1'b0);
        chk("R1", "reset raises tst_halted", tst_halted, 1'b1);
        phase     = "R4";
        ref_rst_n = 1'b1;
        wait_ref(100);
        chk("R4", "relock after reset", ref_running, 1'b1);

        summary();
        $finish;
    end

endmodule